// File: doc/BRIEF.md
# Serial Controller Status Register

This block keeps the read-only status word of a synchronous serial transmit/receive controller. It tracks whether each direction is enabled, catches one-cycle event strobes from the framing logic (sync seen on either side, compare 0 or compare 1 matched) in sticky flags, and follows the occupancy of the receive and transmit holding registers. It also watches the transmit shift register's busy line.

Software reads the word through a simple read port. A read strobe whose address equals the status offset returns the word one cycle later. The same strobe clears the sticky flags. Enable and disable requests arrive as one-cycle command pulses. A disable request is not acted on at once. The enable bit drops only when the affected datapath has gone idle. The shifting, framing and clock generation live elsewhere and appear here only as strobes.

Top module: `ser_status_reg`

## Requirements
- R1: A read with `rd_en` high and `rd_addr` equal to 0x40 drives `rd_data`, on the next cycle, with the status word as it stood before that edge. In that word every bit other than 17, 16, 11, 10, 9, 8, 5, 4, 1 and 0 is zero. A read at any other address returns zero and clears nothing.
- R2: An enable command (`rx_on_cmd` or `tx_on_cmd`) sets the receive enable bit 17 or the transmit enable bit 16 at the next edge.
- R3: After `rx_off_cmd`, bit 17 stays set while `rx_busy` is high. It clears at the first edge at which the request is outstanding and `rx_busy` is low.
- R4: After `tx_off_cmd`, bit 16 stays set while the transmit holding register is full or `shift_busy` is high. It clears at the first edge at which both are clear.
- R5: A sync or compare strobe sets its sticky flag: receive sync on bit 11, transmit sync on bit 10, compare 1 on bit 9, compare 0 on bit 8. The flag stays set until a status read, which returns it set and clears it.
- R6: When a set strobe and a status read fall in the same cycle, the set wins. That read returns the old value, and the flag is still set at the next read.
- R7: Receive ready (bit 4) sets when `rhr_load` pulses. It clears when `rhr_read` pulses without a load in the same cycle.
- R8: Overrun (bit 5) sets when `rhr_load` pulses while bit 4 is already set and no `rhr_read` occurs that cycle. Only a status read clears it. A holding-register read leaves it unchanged.
- R9: Transmit ready (bit 0) is high exactly when the transmit holding register is empty. `thr_write` fills the register, and `thr_xfer` without a write empties it.
- R10: Transmit empty (bit 1) is high only when the holding register is empty and `shift_busy` is low.
- R11: After reset both enable bits and all sticky flags are clear, and the status word reads 0x00000003.
- R12: An enable command that arrives while a disable is still waiting cancels the disable. The enable bit then stays set after the datapath goes idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_on_cmd | input | 1 | Receive enable command pulse |
| rx_off_cmd | input | 1 | Receive disable command pulse |
| tx_on_cmd | input | 1 | Transmit enable command pulse |
| tx_off_cmd | input | 1 | Transmit disable command pulse |
| rx_busy | input | 1 | Receive data currently in progress |
| rx_sync_evt | input | 1 | Receive sync strobe |
| tx_sync_evt | input | 1 | Transmit sync strobe |
| cmp0_evt | input | 1 | Compare 0 match strobe |
| cmp1_evt | input | 1 | Compare 1 match strobe |
| rhr_load | input | 1 | Receive holding register loaded |
| rhr_read | input | 1 | Receive holding register read |
| thr_write | input | 1 | Transmit holding register written |
| thr_xfer | input | 1 | Transmit holding data moved to shift register |
| shift_busy | input | 1 | Transmit shift register is shifting |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | DATA_W | Registered read data |

## Verification
Several pairs of functions can fall in the same cycle, and the bench drives each pair deliberately. A sticky flag's set strobe can land in the cycle of the status read that would clear it. A disable request can meet a datapath that is just going idle, or a fresh enable. A receive load can land on a full holding register while that register is being read. Directed steps place a compare strobe on a read cycle and look for it at the following read. Random traffic mixes all strobes with frequent reads. Every returned word is judged against a cycle model built from the requirements, with busy lines and holding states sampled in the read cycle.

// File: rtl/ser_status_pkg.sv
`timescale 1ns/1ps
package ser_status_pkg;
  // Bit positions inside the status word
  localparam int unsigned POS_RXEN    = 17;
  localparam int unsigned POS_TXEN    = 16;
  localparam int unsigned POS_RXSYN   = 11;
  localparam int unsigned POS_TXSYN   = 10;
  localparam int unsigned POS_CP1     = 9;
  localparam int unsigned POS_CP0     = 8;
  localparam int unsigned POS_OVRUN   = 5;
  localparam int unsigned POS_RXRDY   = 4;
  localparam int unsigned POS_TXEMPTY = 1;
  localparam int unsigned POS_TXRDY   = 0;

  // Index of each sticky flag inside the sticky vector
  localparam int unsigned SF_CP0   = 0;
  localparam int unsigned SF_CP1   = 1;
  localparam int unsigned SF_TXSYN = 2;
  localparam int unsigned SF_RXSYN = 3;
  localparam int unsigned SF_OVRUN = 4;
  localparam int unsigned SF_COUNT = 5;

  // Lanes of the enable trackers
  localparam int unsigned LANE_RX = 0;
  localparam int unsigned LANE_TX = 1;
  localparam int unsigned LANES   = 2;
endpackage

// File: rtl/ser_enable_track.sv
`timescale 1ns/1ps
module ser_enable_track (
  input  logic clk,
  input  logic rst,
  input  logic on_cmd,
  input  logic off_cmd,
  input  logic idle,
  output logic en
);
  logic pend;

  always_ff @(posedge clk) begin
    if (rst) begin
      en   <= 1'b0;
      pend <= 1'b0;
    end else if (on_cmd) begin
      en   <= 1'b1;
      pend <= 1'b0;
    end else if ((off_cmd || pend) && en) begin
      if (idle) begin
        en   <= 1'b0;
        pend <= 1'b0;
      end else begin
        pend <= 1'b1;
      end
    end else begin
      pend <= 1'b0;
    end
  end

  AST_EN_SET: assert property (@(posedge clk) disable iff (rst)
    on_cmd |=> en); // R2
  AST_EN_HOLD_BUSY: assert property (@(posedge clk) disable iff (rst)
    (en && !idle) |=> en); // R3
  AST_EN_NO_SELF_SET: assert property (@(posedge clk) disable iff (rst)
    (!en && !on_cmd) |=> !en); // R2
endmodule

// File: rtl/ser_sticky_flags.sv
`timescale 1ns/1ps
module ser_sticky_flags #(
  parameter int unsigned N = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set,
  input  logic         clr,
  output logic [N-1:0] flag
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst)          flag[i] <= 1'b0;
      else if (set[i])  flag[i] <= 1'b1;
      else if (clr)     flag[i] <= 1'b0;
    end

    AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
      set[i] |=> flag[i]); // R6
    AST_CLEAR_ON_READ: assert property (@(posedge clk) disable iff (rst)
      (clr && !set[i]) |=> !flag[i]); // R5
    AST_KEEP_UNTIL_READ: assert property (@(posedge clk) disable iff (rst)
      (flag[i] && !clr) |=> flag[i]); // R5
  end
endmodule

// File: rtl/ser_rx_hold.sv
`timescale 1ns/1ps
module ser_rx_hold (
  input  logic clk,
  input  logic rst,
  input  logic load,
  input  logic read,
  output logic rdy,
  output logic ovr_set
);
  assign ovr_set = load && rdy && !read;

  always_ff @(posedge clk) begin
    if (rst)       rdy <= 1'b0;
    else if (load) rdy <= 1'b1;
    else if (read) rdy <= 1'b0;
  end

  AST_RXRDY_LOAD: assert property (@(posedge clk) disable iff (rst)
    load |=> rdy); // R7
  AST_RXRDY_DRAIN: assert property (@(posedge clk) disable iff (rst)
    (read && !load) |=> !rdy); // R7
endmodule

// File: rtl/ser_tx_hold.sv
`timescale 1ns/1ps
module ser_tx_hold (
  input  logic clk,
  input  logic rst,
  input  logic write,
  input  logic xfer,
  output logic full
);
  always_ff @(posedge clk) begin
    if (rst)        full <= 1'b0;
    else if (write) full <= 1'b1;
    else if (xfer)  full <= 1'b0;
  end

  AST_THR_FILL: assert property (@(posedge clk) disable iff (rst)
    write |=> full); // R9
  AST_THR_DRAIN: assert property (@(posedge clk) disable iff (rst)
    (xfer && !write) |=> !full); // R9
endmodule

// File: rtl/ser_status_reg.sv
`timescale 1ns/1ps
module ser_status_reg
  import ser_status_pkg::*;
#(
  parameter int unsigned ADDR_W      = 8,
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned STAT_OFFSET = 'h40
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_on_cmd,
  input  logic              rx_off_cmd,
  input  logic              tx_on_cmd,
  input  logic              tx_off_cmd,
  input  logic              rx_busy,
  input  logic              rx_sync_evt,
  input  logic              tx_sync_evt,
  input  logic              cmp0_evt,
  input  logic              cmp1_evt,
  input  logic              rhr_load,
  input  logic              rhr_read,
  input  logic              thr_write,
  input  logic              thr_xfer,
  input  logic              shift_busy,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  localparam logic [ADDR_W-1:0] HIT_ADDR = ADDR_W'(STAT_OFFSET);
  localparam logic [DATA_W-1:0] USED_MASK =
    (DATA_W'(1) << POS_RXEN)  | (DATA_W'(1) << POS_TXEN)  |
    (DATA_W'(1) << POS_RXSYN) | (DATA_W'(1) << POS_TXSYN) |
    (DATA_W'(1) << POS_CP1)   | (DATA_W'(1) << POS_CP0)   |
    (DATA_W'(1) << POS_OVRUN) | (DATA_W'(1) << POS_RXRDY) |
    (DATA_W'(1) << POS_TXEMPTY) | (DATA_W'(1) << POS_TXRDY);

  logic                stat_hit;
  logic                thr_full;
  logic                rx_rdy;
  logic                ovr_set;
  logic [SF_COUNT-1:0] sf_set;
  logic [SF_COUNT-1:0] sf_flag;
  logic [LANES-1:0]    on_v, off_v, idle_v, en_v;
  logic [DATA_W-1:0]   word;

  assign stat_hit = rd_en && (rd_addr == HIT_ADDR);

  // Enable lanes: receive idles on rx_busy low, transmit on both stages empty
  assign on_v[LANE_RX]   = rx_on_cmd;
  assign off_v[LANE_RX]  = rx_off_cmd;
  assign idle_v[LANE_RX] = !rx_busy;
  assign on_v[LANE_TX]   = tx_on_cmd;
  assign off_v[LANE_TX]  = tx_off_cmd;
  assign idle_v[LANE_TX] = !thr_full && !shift_busy;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    ser_enable_track i_en (
      .clk    (clk),
      .rst    (rst),
      .on_cmd (on_v[l]),
      .off_cmd(off_v[l]),
      .idle   (idle_v[l]),
      .en     (en_v[l])
    );
  end

  ser_rx_hold i_rx (
    .clk    (clk),
    .rst    (rst),
    .load   (rhr_load),
    .read   (rhr_read),
    .rdy    (rx_rdy),
    .ovr_set(ovr_set)
  );

  ser_tx_hold i_tx (
    .clk  (clk),
    .rst  (rst),
    .write(thr_write),
    .xfer (thr_xfer),
    .full (thr_full)
  );

  always_comb begin
    sf_set           = '0;
    sf_set[SF_CP0]   = cmp0_evt;
    sf_set[SF_CP1]   = cmp1_evt;
    sf_set[SF_TXSYN] = tx_sync_evt;
    sf_set[SF_RXSYN] = rx_sync_evt;
    sf_set[SF_OVRUN] = ovr_set;
  end

  ser_sticky_flags #(.N(SF_COUNT)) i_flags (
    .clk (clk),
    .rst (rst),
    .set (sf_set),
    .clr (stat_hit),
    .flag(sf_flag)
  );

  always_comb begin
    word              = '0;
    word[POS_RXEN]    = en_v[LANE_RX];
    word[POS_TXEN]    = en_v[LANE_TX];
    word[POS_RXSYN]   = sf_flag[SF_RXSYN];
    word[POS_TXSYN]   = sf_flag[SF_TXSYN];
    word[POS_CP1]     = sf_flag[SF_CP1];
    word[POS_CP0]     = sf_flag[SF_CP0];
    word[POS_OVRUN]   = sf_flag[SF_OVRUN];
    word[POS_RXRDY]   = rx_rdy;
    word[POS_TXEMPTY] = !thr_full && !shift_busy;
    word[POS_TXRDY]   = !thr_full;
  end

  always_ff @(posedge clk) begin
    if (rst)        rd_data <= '0;
    else if (rd_en) rd_data <= stat_hit ? word : '0;
  end

  AST_UNUSED_BITS_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rd_data & ~USED_MASK) == '0); // R1
  AST_MISS_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rd_en && rd_addr != HIT_ADDR) |=> rd_data == '0); // R1
  AST_EMPTY_NEEDS_RDY: assert property (@(posedge clk) disable iff (rst)
    rd_data[POS_TXEMPTY] |-> rd_data[POS_TXRDY]); // R10
  AST_OVR_SURVIVES_DRAIN: assert property (@(posedge clk) disable iff (rst)
    (sf_flag[SF_OVRUN] && rhr_read && !stat_hit) |=> sf_flag[SF_OVRUN]); // R8
endmodule

// File: tb/test_ser_status_reg.sv
`timescale 1ns/1ps
module test_ser_status_reg;
  localparam int AW = 8;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic rx_on_cmd = 0, rx_off_cmd = 0, tx_on_cmd = 0, tx_off_cmd = 0;
  logic rx_busy = 0, rx_sync_evt = 0, tx_sync_evt = 0, cmp0_evt = 0, cmp1_evt = 0;
  logic rhr_load = 0, rhr_read = 0, thr_write = 0, thr_xfer = 0, shift_busy = 0;
  logic rd_en = 0;
  logic [AW-1:0] rd_addr = '0;
  logic [DW-1:0] rd_data;

  int checks = 0;
  int fails  = 0;

  // Cycle model state
  bit m_rxen, m_txen, m_rxpend, m_txpend, m_rxrdy, m_thrfull;
  bit m_rxsyn, m_txsyn, m_cp1, m_cp0, m_ovr;

  ser_status_reg #(.ADDR_W(AW), .DATA_W(DW), .STAT_OFFSET('h40)) i_ser_status_reg (
    .clk(clk), .rst(rst),
    .rx_on_cmd(rx_on_cmd), .rx_off_cmd(rx_off_cmd),
    .tx_on_cmd(tx_on_cmd), .tx_off_cmd(tx_off_cmd),
    .rx_busy(rx_busy), .rx_sync_evt(rx_sync_evt), .tx_sync_evt(tx_sync_evt),
    .cmp0_evt(cmp0_evt), .cmp1_evt(cmp1_evt),
    .rhr_load(rhr_load), .rhr_read(rhr_read),
    .thr_write(thr_write), .thr_xfer(thr_xfer), .shift_busy(shift_busy),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  function automatic logic [31:0] model_word();
    logic [31:0] w = '0;
    w[17] = m_rxen;  w[16] = m_txen;
    w[11] = m_rxsyn; w[10] = m_txsyn; w[9] = m_cp1; w[8] = m_cp0;
    w[5]  = m_ovr;   w[4]  = m_rxrdy;
    w[1]  = !m_thrfull && !shift_busy;
    w[0]  = !m_thrfull;
    return w;
  endfunction

  function automatic void lane_next(input bit on, input bit off, input bit idle,
                                    inout bit en, inout bit pend);
    if (on) begin en = 1; pend = 0; end
    else if ((off || pend) && en) begin
      if (idle) begin en = 0; pend = 0; end
      else pend = 1;
    end else pend = 0;
  endfunction

  task automatic model_reset();
    m_rxen = 0; m_txen = 0; m_rxpend = 0; m_txpend = 0; m_rxrdy = 0; m_thrfull = 0;
    m_rxsyn = 0; m_txsyn = 0; m_cp1 = 0; m_cp0 = 0; m_ovr = 0;
  endtask

  task automatic clear_strobes();
    rx_on_cmd = 0; rx_off_cmd = 0; tx_on_cmd = 0; tx_off_cmd = 0;
    rx_sync_evt = 0; tx_sync_evt = 0; cmp0_evt = 0; cmp1_evt = 0;
    rhr_load = 0; rhr_read = 0; thr_write = 0; thr_xfer = 0; rd_en = 0;
  endtask

  // One clock cycle with the inputs as currently driven; checks any read
  task automatic step(input string tag);
    logic [31:0] exp;
    bit hit, was_rd, tx_idle, rx_idle, ovr_evt;
    hit     = rd_en && (rd_addr == 8'h40);
    was_rd  = rd_en;
    exp     = hit ? model_word() : 32'h0;
    rx_idle = !rx_busy;
    tx_idle = !m_thrfull && !shift_busy;
    ovr_evt = rhr_load && m_rxrdy && !rhr_read;
    lane_next(rx_on_cmd, rx_off_cmd, rx_idle, m_rxen, m_rxpend);
    lane_next(tx_on_cmd, tx_off_cmd, tx_idle, m_txen, m_txpend);
    m_rxsyn = rx_sync_evt | (m_rxsyn & !hit);
    m_txsyn = tx_sync_evt | (m_txsyn & !hit);
    m_cp1   = cmp1_evt    | (m_cp1 & !hit);
    m_cp0   = cmp0_evt    | (m_cp0 & !hit);
    m_ovr   = ovr_evt     | (m_ovr & !hit);
    m_rxrdy = rhr_load | (m_rxrdy & !rhr_read);
    m_thrfull = thr_write | (m_thrfull & !thr_xfer);
    @(posedge clk);
    @(negedge clk);
    if (was_rd) begin
      checks++;
      if (rd_data !== exp) begin
        fails++;
        $display("FAIL %s read word: got %h expected %h", tag, rd_data, exp);
      end
    end
    clear_strobes();
  endtask

  task automatic rd(input logic [7:0] a, input string tag);
    rd_en = 1; rd_addr = a;
    step(tag);
  endtask

  task automatic chk_bit(input int pos, input bit val, input string tag);
    checks++;
    if (rd_data[pos] !== val) begin
      fails++;
      $display("FAIL %s bit %0d: got %b expected %b", tag, pos, rd_data[pos], val);
    end
  endtask

  initial begin
    #(200000 * 10);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int seed;
    seed = 1234;
    void'($urandom(seed));
    model_reset();
    clear_strobes();
    repeat (3) @(negedge clk);
    rst = 0;

    // R11 reset word
    rd(8'h40, "R11");
    checks++;
    if (rd_data !== 32'h3) begin
      fails++;
      $display("FAIL R11 reset word: got %h expected %h", rd_data, 32'h3);
    end

    // R2 enable commands
    rx_on_cmd = 1; step("R2");
    tx_on_cmd = 1; step("R2");
    rd(8'h40, "R2"); chk_bit(17, 1, "R2"); chk_bit(16, 1, "R2");

    // R3 receive disable waits for idle
    rx_busy = 1; rx_off_cmd = 1; step("R3");
    step("R3");
    rd(8'h40, "R3"); chk_bit(17, 1, "R3");
    rx_busy = 0; step("R3");
    rd(8'h40, "R3"); chk_bit(17, 0, "R3");

    // R12 re-enable cancels pending disable
    rx_on_cmd = 1; step("R12");
    rx_busy = 1; rx_off_cmd = 1; step("R12");
    rx_on_cmd = 1; step("R12");
    rx_busy = 0; step("R12");
    step("R12");
    rd(8'h40, "R12"); chk_bit(17, 1, "R12");

    // R4, R9, R10 transmit disable and holding state
    thr_write = 1; step("R9");
    tx_off_cmd = 1; step("R4");
    rd(8'h40, "R4"); chk_bit(16, 1, "R4"); chk_bit(0, 0, "R9"); chk_bit(1, 0, "R10");
    thr_xfer = 1; shift_busy = 1; step("R4");
    rd(8'h40, "R4"); chk_bit(16, 1, "R4"); chk_bit(0, 1, "R9"); chk_bit(1, 0, "R10");
    shift_busy = 0; step("R4");
    rd(8'h40, "R4"); chk_bit(16, 0, "R4"); chk_bit(1, 1, "R10");

    // R5 sticky events clear on status read
    rx_sync_evt = 1; tx_sync_evt = 1; step("R5");
    cmp0_evt = 1; step("R5");
    repeat (3) step("R5");
    rd(8'h40, "R5");
    chk_bit(11, 1, "R5"); chk_bit(10, 1, "R5"); chk_bit(8, 1, "R5");
    rd(8'h40, "R5");
    chk_bit(11, 0, "R5"); chk_bit(10, 0, "R5"); chk_bit(8, 0, "R5");

    // R6 set and read together
    cmp1_evt = 1; rd(8'h40, "R6"); chk_bit(9, 0, "R6");
    rd(8'h40, "R6"); chk_bit(9, 1, "R6");

    // R1 miss address returns zero and leaves flags
    cmp0_evt = 1; step("R1");
    rd(8'h44, "R1");
    checks++;
    if (rd_data !== 32'h0) begin
      fails++;
      $display("FAIL R1 miss read: got %h expected %h", rd_data, 32'h0);
    end
    rd(8'h40, "R1"); chk_bit(8, 1, "R1");

    // R7, R8 receive ready and overrun
    rhr_load = 1; step("R7");
    rd(8'h40, "R7"); chk_bit(4, 1, "R7"); chk_bit(5, 0, "R8");
    rhr_load = 1; step("R8");
    rhr_read = 1; step("R7");
    rd(8'h40, "R8"); chk_bit(4, 0, "R7"); chk_bit(5, 1, "R8");
    rd(8'h40, "R8"); chk_bit(5, 0, "R8");
    rhr_load = 1; step("R8");
    rhr_load = 1; rhr_read = 1; step("R8");
    rd(8'h40, "R8"); chk_bit(4, 1, "R7"); chk_bit(5, 0, "R8");

    // Random traffic against the cycle model
    for (int n = 0; n < 4000; n++) begin
      rx_on_cmd   = ($urandom % 16) == 0;
      rx_off_cmd  = ($urandom % 12) == 0;
      tx_on_cmd   = ($urandom % 16) == 0;
      tx_off_cmd  = ($urandom % 12) == 0;
      if (($urandom % 6) == 0) rx_busy = ~rx_busy;
      if (($urandom % 5) == 0) shift_busy = ~shift_busy;
      rx_sync_evt = ($urandom % 10) == 0;
      tx_sync_evt = ($urandom % 10) == 0;
      cmp0_evt    = ($urandom % 10) == 0;
      cmp1_evt    = ($urandom % 10) == 0;
      rhr_load    = ($urandom % 5) == 0;
      rhr_read    = ($urandom % 5) == 0;
      thr_write   = ($urandom % 6) == 0;
      thr_xfer    = ($urandom % 5) == 0;
      rd_en       = ($urandom % 3) == 0;
      rd_addr     = (($urandom % 8) == 0) ? 8'h3C : 8'h40;
      step("R1 random");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule